// File: doc/BRIEF.md
# Multi-Channel Command-Bus FIFO Slave

This block is the slave end of a synchronous parallel bus on which a master picks one of up to four channels per transaction. While no transaction runs, the slave reports buffer state on the second byte lane of the data bus. A transaction starts when the master pulls its request low. In that first cycle the master puts a channel number on the low data byte and a direction code on the byte-enable lines. One turnaround cycle follows. Then comes a data phase, gated by an active-low acknowledge from the slave. Through this block the master can exercise every corner of the protocol against a synthesizable peer.

Each direction has one storage array of fixed size. A two-bit strap, captured while reset is held, sets how many channels are active. The strap also sets how the storage is split among those channels, and each channel's share works as a double-buffered ring. On the far side, a plain local port fills the receive (host-to-master) buffers and drains the transmit (master-to-host) buffers. Every stored word keeps its byte enables, so a short final word keeps its valid-byte pattern in both directions.

Top module: `mcfs_slave`

## Requirements
- R1: `strap_i` is sampled on every clock edge while `rst_n` is low and held from then on. 01 enables channel 1, 10 enables channels 1 and 2, and 11 enables channels 1 to 4. A later change of `strap_i` has no effect.
- R2: Strap 00 selects the single-channel simple FIFO protocol, which this block does not serve. No channel is enabled, every status bit is high, and every command is refused.
- R3: Each enabled channel owns 2*HALF_WORDS words per direction with one active channel, HALF_WORDS with two and HALF_WORDS/2 with four. A local write to a full receive channel is ignored, and `lc_rx_space`/`lc_tx_avail` report room and data for each channel.
- R4: In idle, the slave drives only byte lane 1 (`bus_d_oe` = 0010). Bit 11+k is low when receive channel k holds data, and bit 7+k is low when transmit channel k has room. Bits of disabled channels are high.
- R5: The command is taken in the first cycle in which `req_n` is seen low in idle. The channel number comes from bits 7:0 and must be 1 to 4. Byte enables 0000 mean master read and 0001 mean master write. The next cycle is a turnaround in which the slave drives nothing.
- R6: In the data phase, `ack_n` is low while the selected receive channel has data (read) or the selected transmit channel has room (write). One word moves on every edge at which both `req_n` and `ack_n` are low.
- R7: `ack_n` rises in the cycle after the last word or slot is used. It stays high until `req_n` rises, even if the local side refills the channel meanwhile. No word moves beyond capacity.
- R8: A command with a channel number of 0 or above 4, a disabled channel, or any other byte-enable code is never acknowledged.
- R9: In a read data phase, the slave drives all lanes and `bus_be_oe`. It presents receive words in arrival order, each with the byte enables stored alongside it.
- R10: Written words and their byte enables are stored in order. `lc_tx_data`/`lc_tx_be` show the head of the channel named by `lc_tx_ch`, and `lc_tx_rd` removes it.
- R11: A high `req_n` outside idle ends the transaction, and the next cycle is idle with status driven.
- R12: Local reads of an empty or disabled channel and local writes to a disabled channel change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and local clock |
| rst_n | input | 1 | Synchronous active-low reset; strap capture window |
| strap_i | input | 2 | Channel-count strap |
| req_n | input | 1 | Master transaction request, active low |
| bus_d_i | input | DATA_W | Data driven by the master |
| bus_be_i | input | DATA_W/8 | Byte enables / command code from the master |
| bus_d_o | output | DATA_W | Data driven by the slave |
| bus_d_oe | output | DATA_W/8 | Per-lane drive enable of `bus_d_o` |
| bus_be_o | output | DATA_W/8 | Byte enables driven by the slave on reads |
| bus_be_oe | output | 1 | Drive enable of `bus_be_o` |
| ack_n | output | 1 | Data-phase acknowledge, active low |
| lc_rx_wr | input | 1 | Local write into a receive channel |
| lc_rx_ch | input | 2 | Receive channel index (0 = channel 1) |
| lc_rx_data | input | DATA_W | Local write data |
| lc_rx_be | input | DATA_W/8 | Byte enables stored with the local word |
| lc_rx_space | output | 4 | Per-channel receive room |
| lc_tx_rd | input | 1 | Local removal of a transmit word |
| lc_tx_ch | input | 2 | Transmit channel index (0 = channel 1) |
| lc_tx_data | output | DATA_W | Head word of the selected transmit channel |
| lc_tx_be | output | DATA_W/8 | Byte enables of that head word |
| lc_tx_avail | output | 4 | Per-channel transmit data present |

## Verification
Some properties are checked on every cycle. Fill counts never exceed the mode's capacity and move by at most one per edge. The acknowledge, once withdrawn in a data phase, stays withdrawn. A refused command lands in the reject phase with no acknowledge. The turnaround cycle leaves every lane undriven. A released request always returns to idle. Word order, stored byte enables, the exact status pattern of each strap, the effect of a late strap change and the no-refill rule after a withdrawn acknowledge can only be shown by the bench's scenarios, which compare against a queue model cycle by cycle.

// File: rtl/mcfs_pkg.sv
package mcfs_pkg;

   localparam int unsigned MCFS_NCH = 4;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_TURN   = 2'd1,
      PH_DATA   = 2'd2,
      PH_REJECT = 2'd3
   } mcfs_phase_e;

   // enabled channel set for a captured strap
   function automatic logic [MCFS_NCH-1:0] mcfs_chan_mask(input logic [1:0] strap);
      case (strap)
         2'b01:   return 4'b0001;
         2'b10:   return 4'b0011;
         2'b11:   return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

   // log2 of the storage split for a captured strap
   function automatic int unsigned mcfs_split_shift(input logic [1:0] strap);
      case (strap)
         2'b10:   return 1;
         2'b11:   return 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/mcfs_chan_store.sv
module mcfs_chan_store
   import mcfs_pkg::*;
#(
   parameter int unsigned HALF_WORDS = 16,
   parameter int unsigned WORD_W     = 36
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          strap_q,
   input  logic [MCFS_NCH-1:0] chan_en,
   input  logic                push,
   input  logic [1:0]          push_ch,
   input  logic [WORD_W-1:0]   push_word,
   input  logic                pop,
   input  logic [1:0]          pop_ch,
   output logic [WORD_W-1:0]   head_word,
   output logic [MCFS_NCH-1:0] not_empty,
   output logic [MCFS_NCH-1:0] not_full
);
   localparam int unsigned TOTAL = 2 * HALF_WORDS;
   localparam int unsigned AW    = $clog2(TOTAL);
   localparam int unsigned CW    = AW + 1;

   if (HALF_WORDS < 4 || (HALF_WORDS & (HALF_WORDS - 1)) != 0) begin : g_bad_depth
      $error("mcfs_chan_store: HALF_WORDS must be a power of two of at least 4");
   end

   logic [WORD_W-1:0]   mem [TOTAL];
   logic [AW-1:0]       wr_off [MCFS_NCH];
   logic [AW-1:0]       rd_off [MCFS_NCH];
   logic [CW-1:0]       fill   [MCFS_NCH];
   logic [CW-1:0]       cap;
   logic [AW-1:0]       wrap_mask;
   int unsigned         sh;
   logic                push_ok, pop_ok;
   logic [AW-1:0]       wr_addr, rd_addr;
   logic [MCFS_NCH-1:0] inc_v, dec_v;

   always_comb begin
      sh        = mcfs_split_shift(strap_q);
      cap       = CW'(TOTAL) >> sh;
      wrap_mask = AW'(cap - CW'(1));
      for (int k = 0; k < MCFS_NCH; k++) begin
         not_empty[k] = chan_en[k] && (fill[k] != '0);
         not_full[k]  = chan_en[k] && (fill[k] < cap);
      end
      push_ok = push && not_full[push_ch];
      pop_ok  = pop && not_empty[pop_ch];
      for (int k = 0; k < MCFS_NCH; k++) begin
         inc_v[k] = push_ok && (push_ch == 2'(k));
         dec_v[k] = pop_ok && (pop_ch == 2'(k));
      end
      // channel region base is index * capacity; capacity is a power of two
      wr_addr   = (AW'(push_ch) << (AW - sh)) | wr_off[push_ch];
      rd_addr   = (AW'(pop_ch) << (AW - sh)) | rd_off[pop_ch];
      head_word = mem[rd_addr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < MCFS_NCH; k++) begin
            wr_off[k] <= '0;
            rd_off[k] <= '0;
            fill[k]   <= '0;
         end
      end else begin
         for (int k = 0; k < MCFS_NCH; k++) begin
            if (inc_v[k]) wr_off[k] <= (wr_off[k] + AW'(1)) & wrap_mask;
            if (dec_v[k]) rd_off[k] <= (rd_off[k] + AW'(1)) & wrap_mask;
            fill[k] <= fill[k] + CW'(inc_v[k]) - CW'(dec_v[k]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_addr] <= push_word;
   end

   for (genvar g = 0; g < MCFS_NCH; g++) begin : g_fill_chk
      // R3
      fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fill[g] <= cap);
      // R6
      fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fill[g] != $past(fill[g])) |->
            ((fill[g] == $past(fill[g]) + CW'(1)) || (fill[g] + CW'(1) == $past(fill[g]))));
   end

endmodule

// File: rtl/mcfs_cmd_fsm.sv
module mcfs_cmd_fsm
   import mcfs_pkg::*;
#(
   parameter int unsigned BE_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_n,
   input  logic [7:0]          cmd_chan,
   input  logic [BE_W-1:0]     cmd_be,
   input  logic [MCFS_NCH-1:0] chan_en,
   input  logic [MCFS_NCH-1:0] rx_has,
   input  logic [MCFS_NCH-1:0] tx_room,
   output mcfs_phase_e         phase,
   output logic [1:0]          sel_ch,
   output logic                sel_wr,
   output logic                ack_n,
   output logic                beat
);
   logic done;
   logic cmd_ok, dir_ok, avail;

   always_comb begin
      dir_ok = (cmd_be == '0) || (cmd_be == BE_W'(1));
      cmd_ok = (cmd_chan >= 8'd1) && (cmd_chan <= 8'd4) &&
               chan_en[cmd_chan[1:0] - 2'd1] && dir_ok;
      avail  = sel_wr ? tx_room[sel_ch] : rx_has[sel_ch];
      ack_n  = !((phase == PH_DATA) && !done && avail);
      beat   = !ack_n && !req_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         sel_ch <= '0;
         sel_wr <= 1'b0;
         done   <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: if (!req_n) begin
               sel_ch <= cmd_chan[1:0] - 2'd1;
               sel_wr <= cmd_be[0];
               phase  <= cmd_ok ? PH_TURN : PH_REJECT;
            end
            PH_TURN: begin
               done  <= 1'b0;
               phase <= req_n ? PH_IDLE : PH_DATA;
            end
            PH_DATA: begin
               if (!avail) done <= 1'b1;
               if (req_n) phase <= PH_IDLE;
            end
            default: if (req_n) phase <= PH_IDLE;
         endcase
      end
   end

   // R7
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && !req_n && ack_n && $past(phase == PH_DATA && !ack_n)) |=> ack_n);
   // R8
   reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !req_n && !cmd_ok) |=> (phase == PH_REJECT && ack_n));
   // R11
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && req_n) |=> (phase == PH_IDLE));

endmodule

// File: rtl/mcfs_slave.sv
module mcfs_slave
   import mcfs_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned HALF_WORDS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            strap_i,
   input  logic                  req_n,
   input  logic [DATA_W-1:0]     bus_d_i,
   input  logic [DATA_W/8-1:0]   bus_be_i,
   output logic [DATA_W-1:0]     bus_d_o,
   output logic [DATA_W/8-1:0]   bus_d_oe,
   output logic [DATA_W/8-1:0]   bus_be_o,
   output logic                  bus_be_oe,
   output logic                  ack_n,
   input  logic                  lc_rx_wr,
   input  logic [1:0]            lc_rx_ch,
   input  logic [DATA_W-1:0]     lc_rx_data,
   input  logic [DATA_W/8-1:0]   lc_rx_be,
   output logic [MCFS_NCH-1:0]   lc_rx_space,
   input  logic                  lc_tx_rd,
   input  logic [1:0]            lc_tx_ch,
   output logic [DATA_W-1:0]     lc_tx_data,
   output logic [DATA_W/8-1:0]   lc_tx_be,
   output logic [MCFS_NCH-1:0]   lc_tx_avail
);
   localparam int unsigned BE_W   = DATA_W / 8;
   localparam int unsigned WORD_W = DATA_W + BE_W;

   if (DATA_W != 16 && DATA_W != 32) begin : g_bad_width
      $error("mcfs_slave: DATA_W must be 16 or 32");
   end

   logic [1:0]          strap_q;
   logic [MCFS_NCH-1:0] chan_en, rx_has, rx_room, tx_has, tx_room;
   logic [WORD_W-1:0]   rx_head, tx_head;
   logic [7:0]          status;
   logic [DATA_W-1:0]   idle_word;
   mcfs_phase_e         phase;
   logic [1:0]          sel_ch;
   logic                sel_wr, beat;

   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_i;
   end

   assign chan_en = mcfs_chan_mask(strap_q);
   assign status  = {~rx_has, ~tx_room};

   if (DATA_W > 16) begin : g_wide
      assign idle_word = {{(DATA_W - 16){1'b0}}, status, 8'h00};
   end else begin : g_narrow
      assign idle_word = {status, 8'h00};
   end

   mcfs_cmd_fsm #(.BE_W(BE_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_n    (req_n),
      .cmd_chan (bus_d_i[7:0]),
      .cmd_be   (bus_be_i),
      .chan_en  (chan_en),
      .rx_has   (rx_has),
      .tx_room  (tx_room),
      .phase    (phase),
      .sel_ch   (sel_ch),
      .sel_wr   (sel_wr),
      .ack_n    (ack_n),
      .beat     (beat)
   );

   mcfs_chan_store #(.HALF_WORDS(HALF_WORDS), .WORD_W(WORD_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_q   (strap_q),
      .chan_en   (chan_en),
      .push      (lc_rx_wr),
      .push_ch   (lc_rx_ch),
      .push_word ({lc_rx_be, lc_rx_data}),
      .pop       (beat && !sel_wr),
      .pop_ch    (sel_ch),
      .head_word (rx_head),
      .not_empty (rx_has),
      .not_full  (rx_room)
   );

   mcfs_chan_store #(.HALF_WORDS(HALF_WORDS), .WORD_W(WORD_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_q   (strap_q),
      .chan_en   (chan_en),
      .push      (beat && sel_wr),
      .push_ch   (sel_ch),
      .push_word ({bus_be_i, bus_d_i}),
      .pop       (lc_tx_rd),
      .pop_ch    (lc_tx_ch),
      .head_word (tx_head),
      .not_empty (tx_has),
      .not_full  (tx_room)
   );

   always_comb begin
      bus_d_o   = '0;
      bus_d_oe  = '0;
      bus_be_o  = rx_head[WORD_W-1:DATA_W];
      bus_be_oe = 1'b0;
      if (phase == PH_IDLE) begin
         bus_d_o  = idle_word;
         bus_d_oe = BE_W'(2);
      end else if (phase == PH_DATA && !sel_wr) begin
         bus_d_o   = rx_head[DATA_W-1:0];
         bus_d_oe  = '1;
         bus_be_oe = 1'b1;
      end
   end

   assign lc_rx_space = rx_room;
   assign lc_tx_avail = tx_has;
   assign lc_tx_data  = tx_head[DATA_W-1:0];
   assign lc_tx_be    = tx_head[WORD_W-1:DATA_W];

   // R5
   turn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TURN) |-> (bus_d_oe == '0 && !bus_be_oe));
   // R9
   read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !sel_wr) |-> (bus_d_oe == '1 && bus_be_oe));
   // R1
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(strap_q));

endmodule

// File: tb/tb_mcfs_slave.sv
module tb_mcfs_slave;
   localparam int HALF = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  strap_i = 2'b11;
   logic        req_n = 1'b1;
   logic [31:0] bus_d_i = '1;
   logic [3:0]  bus_be_i = '1;
   logic [31:0] bus_d_o;
   logic [3:0]  bus_d_oe, bus_be_o;
   logic        bus_be_oe, ack_n;
   logic        lc_rx_wr = 1'b0;
   logic [1:0]  lc_rx_ch = '0;
   logic [31:0] lc_rx_data = '0;
   logic [3:0]  lc_rx_be = '0;
   logic [3:0]  lc_rx_space, lc_tx_avail;
   logic        lc_tx_rd = 1'b0;
   logic [1:0]  lc_tx_ch = '0;
   logic [31:0] lc_tx_data;
   logic [3:0]  lc_tx_be;

   int errors = 0, checks = 0;
   bit live = 0, finished = 0;
   int seq = 0;

   // behavioural model
   logic [35:0] rxq [4][$];
   logic [35:0] txq [4][$];
   int mst = 0, mch = 0, mdone = 0;
   bit mwr = 0;
   logic [1:0] mmode = 2'b00;

   always #2.5 clk = ~clk;

   mcfs_slave #(.DATA_W(32), .HALF_WORDS(HALF)) dut (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .req_n(req_n),
      .bus_d_i(bus_d_i), .bus_be_i(bus_be_i), .bus_d_o(bus_d_o), .bus_d_oe(bus_d_oe),
      .bus_be_o(bus_be_o), .bus_be_oe(bus_be_oe), .ack_n(ack_n),
      .lc_rx_wr(lc_rx_wr), .lc_rx_ch(lc_rx_ch), .lc_rx_data(lc_rx_data), .lc_rx_be(lc_rx_be),
      .lc_rx_space(lc_rx_space), .lc_tx_rd(lc_tx_rd), .lc_tx_ch(lc_tx_ch),
      .lc_tx_data(lc_tx_data), .lc_tx_be(lc_tx_be), .lc_tx_avail(lc_tx_avail)
   );

   function automatic int nen(input logic [1:0] m);
      return (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : (m == 2'b11) ? 4 : 0;
   endfunction

   function automatic int capf(input logic [1:0] m);
      return (m == 2'b10) ? HALF : (m == 2'b11) ? HALF / 2 : 2 * HALF;
   endfunction

   function automatic bit m_avail();
      if (mwr) return txq[mch].size() < capf(mmode);
      return rxq[mch].size() > 0;
   endfunction

   function automatic bit exp_ack_n();
      return !(mst == 2 && mdone == 0 && m_avail());
   endfunction

   function automatic logic [7:0] exp_status();
      logic [7:0] s;
      for (int i = 0; i < 4; i++) begin
         s[4+i] = !(i < nen(mmode) && rxq[i].size() > 0);
         s[i]   = !(i < nen(mmode) && txq[i].size() < capf(mmode));
      end
      return s;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // model update on each edge
   always @(posedge clk) begin
      if (!rst_n) begin
         mmode = strap_i;
         for (int i = 0; i < 4; i++) begin
            rxq[i].delete();
            txq[i].delete();
         end
         mst = 0; mdone = 0; mch = 0; mwr = 0;
      end else begin
         int n, cap, c;
         bit bx, lrw, ltr, av;
         n   = nen(mmode);
         cap = capf(mmode);
         bx  = (mst == 2) && !exp_ack_n() && !req_n;
         lrw = lc_rx_wr && int'(lc_rx_ch) < n && rxq[lc_rx_ch].size() < cap;
         ltr = lc_tx_rd && int'(lc_tx_ch) < n && txq[lc_tx_ch].size() > 0;
         av  = m_avail();
         if (bx && !mwr) void'(rxq[mch].pop_front());
         if (bx && mwr) txq[mch].push_back({bus_be_i, bus_d_i});
         if (lrw) rxq[lc_rx_ch].push_back({lc_rx_be, lc_rx_data});
         if (ltr) void'(txq[lc_tx_ch].pop_front());
         case (mst)
            0: if (!req_n) begin
               c = int'(bus_d_i[7:0]);
               mch = (c + 3) % 4;
               mwr = bus_be_i[0];
               mst = (c >= 1 && c <= n && (bus_be_i == 4'h0 || bus_be_i == 4'h1)) ? 1 : 3;
            end
            1: begin mdone = 0; mst = req_n ? 0 : 2; end
            2: begin if (!av) mdone = 1; if (req_n) mst = 0; end
            default: if (req_n) mst = 0;
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      #1;
      if (live && !finished) begin
         logic [3:0] esp, eav;
         bit ea;
         for (int i = 0; i < 4; i++) begin
            esp[i] = i < nen(mmode) && rxq[i].size() < capf(mmode);
            eav[i] = i < nen(mmode) && txq[i].size() > 0;
         end
         ea = exp_ack_n();
         if (mst == 0) begin
            chk(bus_d_oe == 4'b0010, "R4 idle lanes", 64'(bus_d_oe), 64'h2);
            chk(bus_d_o[15:8] == exp_status(), (mmode == 2'b00) ? "R2 status" : "R4 status",
                64'(bus_d_o[15:8]), 64'(exp_status()));
         end
         if (mst == 1) chk(bus_d_oe == 4'h0 && !bus_be_oe, "R5 turnaround", 64'(bus_d_oe), 64'h0);
         chk(ack_n == ea, (mst == 3) ? "R8 ack" : (mst == 2 && mdone != 0) ? "R7 ack" : "R6 ack",
             64'(ack_n), 64'(ea));
         if (mst == 2 && !mwr && !ea) begin
            chk({bus_be_o, bus_d_o} == rxq[mch][0] && bus_d_oe == 4'hF && bus_be_oe,
                "R9 read word", {28'h0, bus_be_o, bus_d_o}, 64'(rxq[mch][0]));
         end
         chk(lc_rx_space == esp, "R3 rx space", 64'(lc_rx_space), 64'(esp));
         chk(lc_tx_avail == eav, "R12 tx avail", 64'(lc_tx_avail), 64'(eav));
         if (eav[lc_tx_ch])
            chk({lc_tx_be, lc_tx_data} == txq[lc_tx_ch][0], "R10 tx head",
                {28'h0, lc_tx_be, lc_tx_data}, 64'(txq[lc_tx_ch][0]));
      end
   end

   task automatic do_reset(input logic [1:0] m);
      live = 0;
      @(negedge clk);
      rst_n = 1'b0; strap_i = m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; live = 1;
   endtask

   task automatic push(input int ch, input int n, input logic [3:0] last_be);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         lc_rx_wr = 1'b1; lc_rx_ch = 2'(ch);
         lc_rx_data = 32'hC000_0000 + 32'(seq++);
         lc_rx_be = (i == n - 1) ? last_be : 4'hF;
      end
      @(negedge clk);
      lc_rx_wr = 1'b0;
   endtask

   task automatic drain(input int ch, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         lc_tx_rd = 1'b1; lc_tx_ch = 2'(ch);
      end
      @(negedge clk);
      lc_tx_rd = 1'b0; lc_tx_ch = 2'd0;
   endtask

   task automatic master(input int ch, input logic [3:0] be, input int ncyc, input int refill);
      @(negedge clk);
      req_n = 1'b0; bus_d_i = {24'hFFFFFF, 8'(ch)}; bus_be_i = be;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         bus_d_i  = 32'hA500_0000 + 32'(seq++);
         bus_be_i = (i == ncyc - 1) ? 4'h3 : 4'hF;
         lc_rx_wr = (i == refill);
         if (i == refill) begin
            lc_rx_ch = 2'(ch - 1); lc_rx_data = 32'hBEEF_0000 + 32'(i); lc_rx_be = 4'hF;
         end
      end
      @(negedge clk);
      req_n = 1'b1; lc_rx_wr = 1'b0; bus_d_i = '1; bus_be_i = '1;
      @(negedge clk);
      #1;
      chk(bus_d_oe == 4'b0010 && ack_n, "R11 back to idle", 64'(bus_d_oe), 64'h2);
   endtask

   task automatic scenario(input logic [1:0] m);
      int n, cap, wch;
      n = nen(m); cap = capf(m);
      do_reset(m);
      #1;
      chk(bus_d_o[15:12] == 4'hF, "R1 reset rx status", 64'(bus_d_o[15:12]), 64'hF);
      chk(bus_d_o[11:8] == ~4'((1 << n) - 1), "R1 reset tx status",
          64'(bus_d_o[11:8]), 64'(~4'((1 << n) - 1)));
      if (m == 2'b11) begin
         strap_i = 2'b00;   // late strap change must be ignored
         repeat (2) @(negedge clk);
         #1;
         chk(bus_d_o[11:8] == 4'h0, "R1 strap held", 64'(bus_d_o[11:8]), 64'h0);
      end
      push(0, 3, 4'h3);
      push(0, cap, 4'h1);                 // overfill, excess refused (R3)
      if (n > 1) push(n - 1, 2, 4'h7);
      master(1, 4'h0, cap + 4, -1);       // read out, ack withdrawn while requesting (R7)
      push(0, 2, 4'h3);
      master(1, 4'h0, 7, 4);              // refill after ack withdrawn (R7)
      wch = (n >= 2) ? 2 : 1;
      master(wch, 4'h1, cap + 3, -1);     // write until full (R6, R7)
      drain(wch - 1, 5);
      master(wch, 4'h1, 3, -1);
      drain(wch - 1, cap + 2);            // includes reads of an empty channel (R12)
      if (n == 4) master(4, 4'h0, 4, -1);
      master(0, 4'h0, 3, -1);             // R8 channel zero
      master(5, 4'h0, 3, -1);             // R8 channel above four
      if (n < 4) master(n + 1, 4'h1, 3, -1);
      master(1, 4'h2, 3, -1);             // R8 bad direction code
      if (n < 4) begin
         push(3, 1, 4'hF);                // write to disabled channel ignored
         #1;
         chk(bus_d_o[15] == 1'b1 && lc_rx_space[3] == 1'b0, "R12 disabled channel",
             64'(bus_d_o[15]), 64'h1);
      end
      push(0, 5, 4'hF);
      master(1, 4'h0, 3, -1);             // master ends early (R11)
   endtask

   initial begin
      scenario(2'b11);
      scenario(2'b10);
      scenario(2'b01);
      scenario(2'b00);
      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL R6 watchdog actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule